// File: doc/BRIEF.md
# System Clock Control Register with Pin Gating

This block holds the 8-bit system clock control register of a small microcontroller. It decides what the clock output pin does: it toggles with the system clock, it is held high, or it is released to high impedance. The choice depends on the current power mode, the register's clock-disable bit and the port direction bit. The register also holds the medium-speed division field, which the divider datapath outside the block decodes.

The block also sets when a newly requested PLL multiplication factor becomes the active one. In immediate mode the active multiplier follows every rewrite of the request, one clock later. In deferred mode the latest request waits in a shadow register. It is copied across only when the chip enters a standby-type mode (sub-active, software standby or watch).

The power mode arrives as a 4-bit code and is registered each clock. The pin is a glitch-free gate built as the system clock ORed with a registered hold level.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset the register reads 0x00 and `mult_act` equals the parameter MULT_RST.
- R2: A write sets bit 7 (clock disable), bit 3 (immediate select) and bits 2..0 (division field) from `reg_wdata`, and `reg_rdata` shows them after the write edge.
- R3: Bits 6..4 always read 0, and writing ones to them changes nothing.
- R4: While the registered power mode is hardware standby (code 8), the register is cleared to 0x00 and writes are ignored.
- R5: Software standby (code 5) keeps the register contents unchanged.
- R6: In modes high-speed (0), medium-speed (1), sub-active (2), sleep (3) and sub-sleep (4), `ck_pin` follows the clock when bit 7 is 0 and is held high when bit 7 is 1. The pin never goes low while the clock is high, and it changes two edges after the mode input changes.
- R7: In software standby (5), watch (6) and direct transition (7), `ck_pin` is held high whatever bit 7 holds.
- R8: `ck_oe` is 0 in hardware standby (8) or when `port_dir` is 0, and 1 otherwise. It follows the mode one edge after the mode input changes.
- R9: With bit 3 clear, `mult_act` keeps its value except on entry into code 2, 5 or 6 from a mode outside that set. On such an entry it loads the latest `mult_req`, two edges after the mode input changes. A move between two modes of that set is not an entry.
- R10: With bit 3 set, a change of `mult_req` appears on `mult_act` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source for the clock pin |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Decoded register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pwr_mode | input | 4 | Power mode code (0..8) |
| port_dir | input | 1 | Port direction bit, 1 selects output |
| mult_req | input | MULT_W | Requested multiplication factor |
| ck_pin | output | 1 | Clock pin value |
| ck_oe | output | 1 | Clock pin output enable; 0 means high impedance |
| mult_act | output | MULT_W | Active multiplication factor |

## Verification
The bench builds the block with MULT_W = 4 and MULT_RST = 2. The multiplier is then wide enough to carry request values up to 9. The reset value is nonzero, so it cannot be confused with a cleared register or with an undriven load. A table walks every power mode with the disable bit both clear and set. Directed sequences then cover deferred loading across mode entries, transitions inside the standby set, and immediate loading.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

   typedef enum logic [3:0] {
      PM_HIGH     = 4'd0,
      PM_MED      = 4'd1,
      PM_SUBACT   = 4'd2,
      PM_SLEEP    = 4'd3,
      PM_SUBSLEEP = 4'd4,
      PM_SWSTBY   = 4'd5,
      PM_WATCH    = 4'd6,
      PM_DIRECT   = 4'd7,
      PM_HWSTBY   = 4'd8
   } pmode_e;

   localparam int          CTL_W     = 8;
   localparam int          BIT_CKOFF = 7;
   localparam int          BIT_IMMED = 3;
   localparam logic [7:0]  WR_MASK   = 8'h8F;

   // modes in which the pin may carry the running clock
   function automatic logic clk_may_run(input pmode_e m);
      return (m == PM_HIGH) || (m == PM_MED) || (m == PM_SUBACT) ||
             (m == PM_SLEEP) || (m == PM_SUBSLEEP);
   endfunction

   // modes whose entry releases a deferred multiplier
   function automatic logic is_load_mode(input pmode_e m);
      return (m == PM_SUBACT) || (m == PM_SWSTBY) || (m == PM_WATCH);
   endfunction

endpackage

// File: rtl/ckc_regfile.sv
module ckc_regfile
   import ckc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   input  logic             hw_clr,
   output logic [CTL_W-1:0] rdata,
   output logic             ckoff,
   output logic             immed
);

   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (hw_clr) ctl_q <= '0;
      else if (we)     ctl_q <= wdata & WR_MASK;
   end

   assign rdata = ctl_q;
   assign ckoff = ctl_q[BIT_CKOFF];
   assign immed = ctl_q[BIT_IMMED];

   // R4
   hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr |=> (rdata == '0));

   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[6:4] == 3'b000));

endmodule

// File: rtl/ckc_pin_gate.sv
module ckc_pin_gate
   import ckc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  pmode_e mode,
   input  logic   ckoff,
   input  logic   port_dir,
   output logic   pin,
   output logic   oe
);

   logic run_d;
   logic hold_q;

   assign run_d = clk_may_run(mode) && !ckoff;

   // hold level changes only at the rising edge, while clk is high,
   // so clk | hold_q never produces a short pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b1;
      else        hold_q <= !run_d;
   end

   assign pin = clk | hold_q;
   assign oe  = port_dir && (mode != PM_HWSTBY);

   // R7
   stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_SWSTBY || mode == PM_WATCH || mode == PM_DIRECT) |=> hold_q);

   // R6
   ckoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ckoff |=> hold_q);

endmodule

// File: rtl/ckc_mult_sel.sv
module ckc_mult_sel
   import ckc_pkg::*;
#(
   parameter int              MULT_W   = 3,
   parameter logic [MULT_W-1:0] MULT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pmode_e            mode,
   input  logic              immed,
   input  logic [MULT_W-1:0] req,
   output logic [MULT_W-1:0] act
);

   logic [MULT_W-1:0] sh_q;
   logic [MULT_W-1:0] act_q;
   pmode_e            prev_q;
   logic              entry;
   logic              rewrite;

   assign entry   = is_load_mode(mode) && !is_load_mode(prev_q);
   assign rewrite = (req != sh_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= MULT_RST;
         prev_q <= PM_HIGH;
      end else begin
         sh_q   <= req;
         prev_q <= mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 act_q <= MULT_RST;
      else if (immed && rewrite)  act_q <= req;
      else if (!immed && entry)   act_q <= sh_q;
   end

   assign act = act_q;

   // R9
   defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!immed && !entry) |=> $stable(act));

   // R9
   defer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!immed && entry) |=> (act == $past(sh_q)));

   // R10
   imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (immed && rewrite) |=> (act == $past(req)));

endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
   import ckc_pkg::*;
#(
   parameter int                MULT_W   = 3,
   parameter logic [MULT_W-1:0] MULT_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [3:0]        pwr_mode,
   input  logic              port_dir,
   input  logic [MULT_W-1:0] mult_req,
   output logic              ck_pin,
   output logic              ck_oe,
   output logic [MULT_W-1:0] mult_act
);

   localparam int MULT_MAX = 8;

   generate
      if (MULT_W < 1 || MULT_W > MULT_MAX) begin : g_bad_width
         $error("sysclk_ctl: MULT_W out of range");
      end
   endgenerate

   pmode_e mode_q;
   logic   ckoff;
   logic   immed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_HIGH;
      else        mode_q <= pmode_e'(pwr_mode);
   end

   ckc_regfile u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .wdata  (reg_wdata),
      .hw_clr (mode_q == PM_HWSTBY),
      .rdata  (reg_rdata),
      .ckoff  (ckoff),
      .immed  (immed)
   );

   ckc_pin_gate u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .ckoff    (ckoff),
      .port_dir (port_dir),
      .pin      (ck_pin),
      .oe       (ck_oe)
   );

   ckc_mult_sel #(
      .MULT_W   (MULT_W),
      .MULT_RST (MULT_RST)
   ) u_mult (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .immed (immed),
      .req   (mult_req),
      .act   (mult_act)
   );

   // R5
   swstby_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_SWSTBY && !reg_we) |=> $stable(reg_rdata));

   // R8
   hw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == 4'd8) |=> !ck_oe);

endmodule

// File: tb/test_sysclk_ctl.sv
`timescale 1ns/1ps
module test_sysclk_ctl;

   localparam int MW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [3:0]    pwr_mode = 4'd0;
   logic          port_dir = 1'b1;
   logic [MW-1:0] mult_req = 4'd2;
   logic          ck_pin;
   logic          ck_oe;
   logic [MW-1:0] mult_act;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   sysclk_ctl #(.MULT_W(MW), .MULT_RST(4'd2)) i_sysclk_ctl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwr_mode(pwr_mode), .port_dir(port_dir),
      .mult_req(mult_req), .ck_pin(ck_pin), .ck_oe(ck_oe), .mult_act(mult_act)
   );

   // {mode[3:0], ckoff, port_dir, held, oe}
   localparam logic [7:0] VEC [20] = '{
      {4'd0,4'b0101}, {4'd0,4'b1111}, {4'd1,4'b0101}, {4'd1,4'b1111},
      {4'd2,4'b0101}, {4'd2,4'b1111}, {4'd3,4'b0101}, {4'd3,4'b1111},
      {4'd4,4'b0101}, {4'd4,4'b1111}, {4'd5,4'b0111}, {4'd5,4'b1111},
      {4'd6,4'b0111}, {4'd7,4'b0111}, {4'd7,4'b1111}, {4'd8,4'b0100},
      {4'd8,4'b1100}, {4'd0,4'b0000}, {4'd5,4'b0000}, {4'd2,4'b1000}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #0.5;
   endtask

   task automatic wr(input logic [7:0] v);
      reg_we = 1'b1;
      reg_wdata = v;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic set_mode(input logic [3:0] m);
      pwr_mode = m;
      tick();
      tick();
   endtask

   initial begin
      #(200000 * 5);
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      tick();
      tick();
      check("R1 reset reg", reg_rdata, 8'h00);
      check("R1 reset mult", 8'(mult_act), 8'h02);
      rst_n = 1'b1;
      tick();
      check("R1 after release", reg_rdata, 8'h00);

      // table walk over power modes
      foreach (VEC[i]) begin
         set_mode(4'd0);
         wr({VEC[i][3], 7'b0});
         port_dir = VEC[i][2];
         set_mode(VEC[i][7:4]);
         check($sformatf("R8 oe vec%0d", i), 8'(ck_oe), 8'(VEC[i][0]));
         if (VEC[i][0])
            check($sformatf("R6 R7 pin vec%0d", i), 8'(ck_pin), 8'(VEC[i][1]));
      end
      port_dir = 1'b1;
      set_mode(4'd0);

      // R6: pin never low while clk high
      wr(8'h00);
      tick();
      @(posedge clk);
      #0.5;
      check("R6 pin high phase", 8'(ck_pin), 8'h01);
      tick();
      check("R6 pin low phase", 8'(ck_pin), 8'h00);

      // R2 / R3
      wr(8'h05);
      check("R2 div field", reg_rdata, 8'h05);
      wr(8'h83);
      check("R2 bit7", reg_rdata, 8'h83);
      wr(8'hFF);
      check("R3 reserved ones", reg_rdata, 8'h8F);
      wr(8'h70);
      check("R3 reserved only", reg_rdata, 8'h00);

      // R5
      wr(8'h8B);
      set_mode(4'd5);
      tick();
      check("R5 swstby keep", reg_rdata, 8'h8B);

      // R4
      set_mode(4'd8);
      check("R4 hwstby clear", reg_rdata, 8'h00);
      wr(8'h8F);
      check("R4 write ignored", reg_rdata, 8'h00);
      set_mode(4'd0);
      check("R4 stays clear", reg_rdata, 8'h00);

      // R9 deferred
      mult_req = 4'd5;
      tick(); tick(); tick();
      check("R9 no early load", 8'(mult_act), 8'h02);
      set_mode(4'd6);
      check("R9 watch entry", 8'(mult_act), 8'h05);
      mult_req = 4'd7;
      set_mode(4'd5);
      check("R9 within set", 8'(mult_act), 8'h05);
      set_mode(4'd0);
      set_mode(4'd3);
      check("R9 sleep no load", 8'(mult_act), 8'h05);
      set_mode(4'd2);
      check("R9 subact entry", 8'(mult_act), 8'h07);
      set_mode(4'd0);

      // R10 immediate
      wr(8'h08);
      mult_req = 4'd9;
      tick();
      check("R10 immediate", 8'(mult_act), 8'h09);
      mult_req = 4'd3;
      tick();
      check("R10 second", 8'(mult_act), 8'h03);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule